// File: doc/BRIEF.md
# Programmable GPIO Input Debounce Filter

This block cleans up one general-purpose input pin before edge or level detection looks at it. The raw pin first passes through a flop synchronizer. A filter then decides when the synchronized level may reach the filtered output. Its time base is a slow real-time tick of about 30.5 µs (32.768 kHz), delivered as a single-cycle enable pulse in the main clock domain.

Software chooses one of four filter behaviours:
- **Bypass.** The filter is off and the input passes straight through.
- **Both polarities filtered.** Glitches of either polarity are removed.
- **Low pulses kept.** Low pulses pass at once, while rising transitions must be stable first.
- **High pulses kept.** The mirror of the previous mode.

The debounce window is a 4-bit count multiplied by a unit that two select bits choose. The unit spans from two ticks (about 61 µs) to 2048 ticks (about 62.5 ms). The block drives the filtered level and a strobe that marks each change of that level. Edge logic downstream can use the strobe directly.

Top module: `gpio_debounce`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pin_filt` and `pin_change` are 0.
- R2: The raw pin passes through a two-flop synchronizer. In bypass mode (`cfg_mode`=0), a change on `pin_raw` sampled at one clock edge appears on `pin_filt` after the third edge.
- R3: In bypass mode every input pulse passes unfiltered, including a pulse one clock cycle long.
- R4: The debounce window is max(`cfg_count`,1) × U ticks. U is selected by {`cfg_large`,`cfg_unit`}: 00 gives 2, 01 gives 8, 10 gives 512 and 11 gives 2048.
- R5: In a filtering direction, a new level is accepted at the clock edge where the tick that completes the window is sampled. The synchronized input must have differed from `pin_filt` for that whole window. A level held for one tick fewer is rejected.
- R6: A return of the input to the current filtered level, however short, clears the count. The next attempt starts from zero.
- R7: A `cfg_count` of 0 with the filter enabled gives a window of one unit, not a bypass.
- R8: With `cfg_mode`=3, both rising and falling transitions are filtered. High glitches and low glitches shorter than the window are both rejected.
- R9: With `cfg_mode`=1, a falling transition reaches `pin_filt` one edge after the synchronizer output, with no tick needed. Rising transitions are filtered.
- R10: With `cfg_mode`=2, a rising transition passes at once. Falling transitions are filtered.
- R11: Any change of the configuration inputs clears the count. At the next edge it also loads the synchronized input into `pin_filt`, with no wait for ticks.
- R12: `pin_change` is high for exactly those cycles in which `pin_filt` differs from its value in the previous cycle.
- R13: Ticks are counted only in cycles where `rtc_tick` is high. Without ticks, a filtered transition is never accepted, however long the input holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | 1 | Asynchronous pin level |
| rtc_tick | input | 1 | Single-cycle enable at the 32.768 kHz rate |
| cfg_mode | input | 2 | 0 bypass, 1 keep low pulses, 2 keep high pulses, 3 filter both |
| cfg_count | input | CNT_W (4) | Window length in units |
| cfg_large | input | 1 | Upper unit select bit |
| cfg_unit | input | 1 | Lower unit select bit |
| pin_filt | output | 1 | Filtered pin level |
| pin_change | output | 1 | One-cycle strobe when `pin_filt` changes |

## Verification
The bench feeds pulses exactly one tick shorter than the window and exactly as long as it, for all four unit selects. A design that counts one tick too many or too few would let the short pulse through or hold back the long one. A bounce placed mid-window catches a counter that accumulates instead of restarting, because the two partial runs add up past the window. Other cases target the modes:
- A zero count catches a bypass that should have been a one-unit delay.
- A configuration write during a pending count catches a design that keeps waiting for ticks.
- The two one-sided modes show whether the immediate direction was wired to the wrong polarity.

// File: rtl/gdb_pkg.sv
package gdb_pkg;

    typedef enum logic [1:0] {
        DBM_OFF       = 2'd0,
        DBM_KEEP_LOW  = 2'd1,
        DBM_KEEP_HIGH = 2'd2,
        DBM_SCRUB     = 2'd3
    } dbm_e;

    localparam int UNIT_SHIFT_MAX = 11;

    // log2 of the tick count per unit for each select value
    function automatic int unsigned unit_shift(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 3;
            2'b10:   return 9;
            default: return 11;
        endcase
    endfunction

endpackage

// File: rtl/gdb_sync.sv
module gdb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] stage_d, stage_q;

    always_comb begin
        stage_d = {stage_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign q_o = stage_q[STAGES-1];

    assert_first_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stage_q[0] == $past(d_i));

endmodule

// File: rtl/gdb_limit.sv
module gdb_limit
    import gdb_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int LIM_W = CNT_W + UNIT_SHIFT_MAX
) (
    input  logic [CNT_W-1:0] count_i,
    input  logic [1:0]       sel_i,
    output logic [LIM_W-1:0] limit_o
);

    logic [CNT_W-1:0] eff_count;

    always_comb begin
        eff_count = (count_i == '0) ? CNT_W'(1) : count_i;
        limit_o   = LIM_W'(eff_count) << unit_shift(sel_i);
    end

endmodule

// File: rtl/gdb_core.sv
module gdb_core
    import gdb_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int LIM_W = CNT_W + UNIT_SHIFT_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_i,
    input  logic             tick_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [1:0]       sel_i,
    input  logic [LIM_W-1:0] limit_i,
    output logic [CNT_W-1:0] count_q_o,
    output logic [1:0]       sel_q_o,
    output logic             filt_o,
    output logic             change_o
);

    localparam int CFG_W = 2 + CNT_W + 2;

    typedef struct packed {
        logic             filt;
        logic             change;
        logic [LIM_W-1:0] cnt;
        logic [CFG_W-1:0] cfg;
    } st_t;

    st_t st_d, st_q;

    logic [CFG_W-1:0] cfg_in;
    logic             cfg_diff;
    dbm_e             mode_q;
    logic             pass_now;

    always_comb begin
        cfg_in   = {mode_i, count_i, sel_i};
        cfg_diff = (cfg_in != st_q.cfg);
        mode_q   = dbm_e'(st_q.cfg[CFG_W-1 -: 2]);
        pass_now = ((mode_q == DBM_KEEP_LOW)  && !s_i) ||
                   ((mode_q == DBM_KEEP_HIGH) &&  s_i);

        st_d     = st_q;
        st_d.cfg = cfg_in;
        if (cfg_diff) begin
            st_d.filt = s_i;
            st_d.cnt  = '0;
        end else if (mode_q == DBM_OFF) begin
            st_d.filt = s_i;
            st_d.cnt  = '0;
        end else if (s_i == st_q.filt) begin
            st_d.cnt = '0;
        end else if (pass_now) begin
            st_d.filt = s_i;
            st_d.cnt  = '0;
        end else if (tick_i) begin
            if (st_q.cnt == limit_i - LIM_W'(1)) begin
                st_d.filt = s_i;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + LIM_W'(1);
            end
        end
        st_d.change = (st_d.filt != st_q.filt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt_o    = st_q.filt;
    assign change_o  = st_q.change;
    assign count_q_o = st_q.cfg[2 +: CNT_W];
    assign sel_q_o   = st_q.cfg[1:0];

    assert_cnt_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < limit_i);

    assert_cfg_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ({mode_i, count_i, sel_i} != st_q.cfg) |=> (filt_o == $past(s_i) && st_q.cnt == '0));

    assert_bypass_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ({mode_i, count_i, sel_i} == st_q.cfg && mode_i == 2'd0) |=> filt_o == $past(s_i));

    assert_no_tick_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        ({mode_i, count_i, sel_i} == st_q.cfg && mode_i == 2'd3 && !tick_i) |=> $stable(filt_o));

    assert_low_passes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ({mode_i, count_i, sel_i} == st_q.cfg && mode_i == 2'd1 && !s_i) |=> !filt_o);

    assert_high_passes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ({mode_i, count_i, sel_i} == st_q.cfg && mode_i == 2'd2 && s_i) |=> filt_o);

    assert_strobe_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> change_o == (filt_o != $past(filt_o)));

endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce
    import gdb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_raw,
    input  logic             rtc_tick,
    input  logic [1:0]       cfg_mode,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             cfg_large,
    input  logic             cfg_unit,
    output logic             pin_filt,
    output logic             pin_change
);

    localparam int LIM_W = CNT_W + UNIT_SHIFT_MAX;

    logic             pin_s;
    logic [CNT_W-1:0] count_q;
    logic [1:0]       sel_q;
    logic [LIM_W-1:0] limit;

    gdb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_raw),
        .q_o   (pin_s)
    );

    gdb_limit #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_limit (
        .count_i (count_q),
        .sel_i   (sel_q),
        .limit_o (limit)
    );

    gdb_core #(.CNT_W(CNT_W), .LIM_W(LIM_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_i       (pin_s),
        .tick_i    (rtc_tick),
        .mode_i    (cfg_mode),
        .count_i   (cfg_count),
        .sel_i     ({cfg_large, cfg_unit}),
        .limit_i   (limit),
        .count_q_o (count_q),
        .sel_q_o   (sel_q),
        .filt_o    (pin_filt),
        .change_o  (pin_change)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!pin_filt && !pin_change));

endmodule

// File: tb/sim_gpio_debounce.sv
module sim_gpio_debounce;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_raw = 1'b0;
    logic       rtc_tick = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [3:0] cfg_count = 4'd0;
    logic       cfg_large = 1'b0;
    logic       cfg_unit = 1'b0;
    logic       pin_filt;
    logic       pin_change;

    int total = 0;
    int fails = 0;
    int strobe_seen = 0;
    int strobe_bad = 0;
    bit done = 0;

    string q_tag[$];
    logic  q_exp[$];
    bit    q_sig[$];
    event  sample_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_debounce u0 (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .rtc_tick(rtc_tick),
        .cfg_mode(cfg_mode), .cfg_count(cfg_count), .cfg_large(cfg_large),
        .cfg_unit(cfg_unit), .pin_filt(pin_filt), .pin_change(pin_change)
    );

    // monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(sample_ev);
            while (q_tag.size() > 0) begin
                string t;
                logic  e;
                logic  a;
                bit    s;
                t = q_tag.pop_front();
                e = q_exp.pop_front();
                s = q_sig.pop_front();
                a = s ? pin_change : pin_filt;
                total++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s: %s actual=%b expected=%b", t,
                             s ? "pin_change" : "pin_filt", a, e);
                end
            end
        end
    end

    // R12: strobe must match every change of the filtered level
    logic prev_filt = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (pin_change) strobe_seen++;
            if (pin_change !== (pin_filt !== prev_filt)) begin
                strobe_bad++;
                total++;
                fails++;
                $display("FAIL R12: pin_change actual=%b expected=%b", pin_change,
                         pin_filt !== prev_filt);
            end
        end
        prev_filt = pin_filt;
    end

    task automatic expect_out(input string tag, input bit sig, input logic v);
        q_tag.push_back(tag);
        q_exp.push_back(v);
        q_sig.push_back(sig);
        ->sample_ev;
        #1;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) rtc_tick = 1'b1;
            @(negedge clk) rtc_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [3:0] c,
                           input logic lg, input logic un);
        @(negedge clk);
        cfg_mode = m; cfg_count = c; cfg_large = lg; cfg_unit = un;
        cycles(2);
    endtask

    task automatic drive(input logic v);
        @(negedge clk) pin_raw = v;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        cycles(5);
        rst_n = 1'b1;
        cycles(1);
        expect_out("R1", 0, 1'b0);
        expect_out("R1", 1, 1'b0);

        // R2: bypass latency of three edges
        drive(1'b1); cycles(2);
        expect_out("R2", 0, 1'b0);
        cycles(1);
        expect_out("R2", 0, 1'b1);
        drive(1'b0); cycles(5);

        // R3: one-cycle pulse passes in bypass
        drive(1'b1); drive(1'b0); cycles(2);
        expect_out("R3", 0, 1'b1);
        cycles(1);
        expect_out("R3", 0, 1'b0);
        cycles(4);

        // filter both, unit 2 ticks, count 3 -> window 6 ticks
        set_cfg(2'd3, 4'd3, 1'b0, 1'b0);
        drive(1'b1); cycles(3); pulse_ticks(5);
        expect_out("R5", 0, 1'b0);
        drive(1'b0); cycles(4);
        expect_out("R8", 0, 1'b0);
        drive(1'b1); cycles(3); pulse_ticks(6);
        expect_out("R5", 0, 1'b1);

        // R13: no ticks, no acceptance
        drive(1'b0); cycles(60);
        expect_out("R13", 0, 1'b1);

        // R6: bounce restarts the count (4 + 5 would exceed 6)
        pulse_ticks(4);
        drive(1'b1); cycles(4);
        drive(1'b0); cycles(3); pulse_ticks(5);
        expect_out("R6", 0, 1'b1);
        pulse_ticks(1);
        expect_out("R6", 0, 1'b0);

        // R8: low glitch rejected in filter-both mode
        drive(1'b1); cycles(3); pulse_ticks(6);
        expect_out("R8", 0, 1'b1);
        drive(1'b0); cycles(3); pulse_ticks(5);
        drive(1'b1); cycles(4);
        expect_out("R8", 0, 1'b1);

        // R11: config write during a pending count reloads at once
        drive(1'b0); cycles(3); pulse_ticks(2);
        @(negedge clk) cfg_count = 4'd4;
        @(negedge clk);
        expect_out("R11", 0, 1'b0);
        expect_out("R11", 1, 1'b1);
        @(negedge clk);
        expect_out("R12", 1, 1'b0);

        // R7: count 0 acts as one unit (2 ticks)
        set_cfg(2'd3, 4'd0, 1'b0, 1'b0);
        drive(1'b1); cycles(3); pulse_ticks(1);
        expect_out("R7", 0, 1'b0);
        pulse_ticks(1);
        expect_out("R7", 0, 1'b1);

        // R4: unit 8 ticks, count 2 -> 16
        set_cfg(2'd3, 4'd2, 1'b0, 1'b1);
        drive(1'b0); cycles(3); pulse_ticks(15);
        expect_out("R4", 0, 1'b1);
        pulse_ticks(1);
        expect_out("R4", 0, 1'b0);

        // R4: unit 512 ticks, count 1
        set_cfg(2'd3, 4'd1, 1'b1, 1'b0);
        drive(1'b1); cycles(3); pulse_ticks(511);
        expect_out("R4", 0, 1'b0);
        pulse_ticks(1);
        expect_out("R4", 0, 1'b1);

        // R4: unit 2048 ticks, count 1
        set_cfg(2'd3, 4'd1, 1'b1, 1'b1);
        drive(1'b0); cycles(3); pulse_ticks(2047);
        expect_out("R4", 0, 1'b1);
        pulse_ticks(1);
        expect_out("R4", 0, 1'b0);

        // R9: keep low pulses
        set_cfg(2'd1, 4'd3, 1'b0, 1'b0);
        drive(1'b1); cycles(3); pulse_ticks(5);
        expect_out("R9", 0, 1'b0);
        pulse_ticks(1);
        expect_out("R9", 0, 1'b1);
        drive(1'b0); cycles(3);
        expect_out("R9", 0, 1'b0);

        // R10: keep high pulses
        set_cfg(2'd2, 4'd3, 1'b0, 1'b0);
        drive(1'b1); cycles(3);
        expect_out("R10", 0, 1'b1);
        drive(1'b0); cycles(3); pulse_ticks(5);
        expect_out("R10", 0, 1'b1);
        pulse_ticks(1);
        expect_out("R10", 0, 1'b0);

        cycles(2);
        total++;
        if (strobe_bad != 0 || strobe_seen == 0) begin
            fails++;
            $display("FAIL R12: strobe mismatches=%0d strobes=%0d expected mismatches=0 strobes>0",
                     strobe_bad, strobe_seen);
        end
        finish_run();
    end

endmodule